// File: doc/BRIEF.md
# I2C Master Repeated-Start Generator

This block is the part of an I2C master that places a repeated start on an open-drain bus. Software sets a request bit through a control write. The block then runs a fixed sequence on the bus. It pulls SCL low, then releases SDA. Next it releases SCL and checks that both lines sit high. Finally it pulls SDA low while SCL stays high. A reloadable down-counter times each phase. The block moves on only when the line levels it reads back agree with what it drives.

The outputs are pull-low enables for SDA and SCL. When an enable is high, the pad drives the line to zero; when it is low, the line floats high. The sampled line levels come back on `sda_in` and `scl_in`.

The block reports five status signals:
- the request bit, which doubles as busy;
- a sticky start-detected flag, taken from the bus levels;
- a completion interrupt;
- a write-collision flag for transmit-buffer writes made during the sequence;
- a bus-collision flag for lost arbitration.

A bus collision aborts the sequence and frees both lines. The sticky flags stay set until `flag_clr` is strobed. When the sequence finishes, SDA is left pulled low, ready for the first bit. It is released only by the next accepted request.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset, `sda_pull`, `scl_pull`, `rs_busy`, `start_det`, `done_irq`, `wcol` and `bcol` are all 0, and `txbuf_q` is 0.
- R2: A request (`req_wr`=1 with `req_data`=1) is accepted only while `rs_busy`=0 and `other_busy`=0. A request with `other_busy`=1, or a write with `req_data`=0, leaves `rs_busy` and `scl_pull` at 0.
- R3: The edge that accepts a request sets `rs_busy` and `scl_pull`. At the first edge where `scl_in` is low, the baud counter loads `reload_val`=N and `sda_pull` goes to 0. Each baud period lasts N+1 clocks.
- R4: Counting the accepting edge as edge 0, SCL is released (`scl_pull`=0) at edge N+2, provided SDA reads high. While `sda_in` reads low at the end of the SDA-release period, `scl_pull` stays 1. SCL is then released on the first edge that sees SDA high.
- R5: At the edge where `scl_in` is first seen high, the counter reloads. Both lines stay released for one baud period. `sda_pull` then rises at edge 2N+4.
- R6: At edge 3N+5, `rs_busy` clears and `done_irq` sets. `sda_pull` stays 1 and `scl_pull` stays 0.
- R7: `start_det` sets one edge after SDA falls while SCL is high on both samples. In a clean sequence this is edge 2N+5.
- R8: A `txbuf_wr` at an edge where `rs_busy`=1 leaves `txbuf_q` unchanged and sets `wcol`. While idle, the write stores `txbuf_wdata` and `wcol` is not touched.
- R9: Control writes while `rs_busy`=1 have no effect. Writing `req_data`=0 does not cancel the sequence, and writing `req_data`=1 does not restart it. Completion still lands at edge 3N+5.
- R10: In the phase waiting for SCL to rise, if `scl_in` reads high while `sda_in` reads low, the next edge does the following: sets `bcol`, clears `rs_busy`, and drops both pull enables.
- R11: During the both-high period, if `scl_in` reads low, the next edge aborts the sequence the same way as R10.
- R12: `start_det`, `done_irq`, `wcol` and `bcol` stay set until an edge with `flag_clr`=1 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Control write strobe for the request bit |
| req_data | input | 1 | Value written to the request bit |
| other_busy | input | 1 | Another master event (start, stop, byte) is in progress |
| reload_val | input | RELOAD_W | Baud counter reload value N |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| txbuf_wr | input | 1 | Transmit-buffer write strobe |
| txbuf_wdata | input | DATA_W | Transmit-buffer write data |
| flag_clr | input | 1 | Clears the sticky status flags |
| sda_pull | output | 1 | Pull SDA low when 1 |
| scl_pull | output | 1 | Pull SCL low when 1 |
| rs_busy | output | 1 | Request bit; 1 while the sequence runs |
| start_det | output | 1 | Sticky start-condition-seen flag |
| done_irq | output | 1 | Sticky completion interrupt |
| wcol | output | 1 | Sticky write-collision flag |
| bcol | output | 1 | Sticky bus-collision flag |
| txbuf_q | output | DATA_W | Transmit-buffer contents |

## Verification
Every result is due at an edge that can be counted from the accepting edge (edge 0):
- SCL release at N+2;
- SDA pull at 2N+4;
- start detection at 2N+5;
- completion at 3N+5;
- collision aborts exactly one edge after the offending line level.

The bench counts rising edges from edge 0 and samples the outputs on each falling edge. It records the first edge at which each output changes and compares it with these formulas across a sweep of N. Stimuli that must land in one phase are applied on the falling edge after the bench has seen that phase's entry on the outputs.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    RS_IDLE        = 3'd0,
    RS_SCL_LOW     = 3'd1,
    RS_SDA_REL     = 3'd2,
    RS_WAIT_SCL_HI = 3'd3,
    RS_HIGH_HOLD   = 3'd4,
    RS_SDA_LOW     = 3'd5
  } rs_state_t;
endpackage

// File: rtl/i2c_rs_line_sync.sv
// Optional sampling stages on the bus lines; 0 stages passes them through.
module i2c_rs_line_sync #(
  parameter int STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_raw,
  input  logic scl_raw,
  output logic sda_s,
  output logic scl_s
);
  generate
    if (STAGES == 0) begin : g_pass
      assign sda_s = sda_raw;
      assign scl_s = scl_raw;
    end else begin : g_sync
      logic [STAGES-1:0] sda_sr;
      logic [STAGES-1:0] scl_sr;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            sda_sr[i] <= 1'b1;
            scl_sr[i] <= 1'b1;
          end else if (i == 0) begin
            sda_sr[i] <= sda_raw;
            scl_sr[i] <= scl_raw;
          end else begin
            sda_sr[i] <= sda_sr[i-1];
            scl_sr[i] <= scl_sr[i-1];
          end
        end
      end
      assign sda_s = sda_sr[STAGES-1];
      assign scl_s = scl_sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_rs_baud.sv
// Reloadable down-counter: a reload of N gives a period of N+1 clocks.
module i2c_rs_baud #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [RELOAD_W-1:0] reload,
  output logic                tout
);
  logic [RELOAD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= reload;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign tout = (cnt_q == '0);
endmodule

// File: rtl/i2c_rs_seq.sv
// Phase sequencer for the repeated start; drives the registered pull enables.
module i2c_rs_seq
  import i2c_rs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_wr,
  input  logic      req_data,
  input  logic      other_busy,
  input  logic      sda_s,
  input  logic      scl_s,
  input  logic      tout,
  output rs_state_t state,
  output logic      cnt_load,
  output logic      done_evt,
  output logic      abort_evt,
  output logic      rs_busy,
  output logic      sda_pull,
  output logic      scl_pull
);
  rs_state_t nxt;
  logic      accept;

  assign accept = req_wr && req_data && !other_busy && (state == RS_IDLE);

  always_comb begin
    nxt       = state;
    cnt_load  = 1'b0;
    done_evt  = 1'b0;
    abort_evt = 1'b0;
    unique case (state)
      RS_IDLE: begin
        if (accept) nxt = RS_SCL_LOW;
      end
      RS_SCL_LOW: begin
        if (!scl_s) begin
          nxt      = RS_SDA_REL;
          cnt_load = 1'b1;
        end
      end
      RS_SDA_REL: begin
        // SCL may only rise once the released SDA actually reads high
        if (tout && sda_s) nxt = RS_WAIT_SCL_HI;
      end
      RS_WAIT_SCL_HI: begin
        if (scl_s) begin
          if (!sda_s) begin
            nxt       = RS_IDLE;
            abort_evt = 1'b1;
          end else begin
            nxt      = RS_HIGH_HOLD;
            cnt_load = 1'b1;
          end
        end
      end
      RS_HIGH_HOLD: begin
        if (!scl_s) begin
          nxt       = RS_IDLE;
          abort_evt = 1'b1;
        end else if (tout) begin
          nxt      = RS_SDA_LOW;
          cnt_load = 1'b1;
        end
      end
      RS_SDA_LOW: begin
        if (tout) begin
          nxt      = RS_IDLE;
          done_evt = 1'b1;
        end
      end
      default: nxt = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RS_IDLE;
      rs_busy  <= 1'b0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      state    <= nxt;
      rs_busy  <= (nxt != RS_IDLE);
      scl_pull <= (nxt == RS_SCL_LOW) || (nxt == RS_SDA_REL);
      if (abort_evt || nxt == RS_SDA_REL) sda_pull <= 1'b0;
      else if (nxt == RS_SDA_LOW)         sda_pull <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rs_status.sv
// Sticky flags, bus start detector and guarded transmit buffer.
module i2c_rs_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_clr,
  input  logic              done_evt,
  input  logic              abort_evt,
  input  logic              busy,
  input  logic              sda_s,
  input  logic              scl_s,
  input  logic              txbuf_wr,
  input  logic [DATA_W-1:0] txbuf_wdata,
  output logic              start_det,
  output logic              done_irq,
  output logic              wcol,
  output logic              bcol,
  output logic [DATA_W-1:0] txbuf_q
);
  localparam int NFLAG = 4;

  logic             sda_prev, scl_prev;
  logic             start_evt, wcol_evt;
  logic [NFLAG-1:0] flag_set, flag_q;

  assign start_evt = sda_prev && !sda_s && scl_prev && scl_s;
  assign wcol_evt  = txbuf_wr && busy;
  assign flag_set  = {abort_evt, wcol_evt, done_evt, start_evt};

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_prev <= 1'b1;
      scl_prev <= 1'b1;
    end else begin
      sda_prev <= sda_s;
      scl_prev <= scl_s;
    end
  end

  generate
    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)              flag_q[f] <= 1'b0;
        else if (flag_set[f]) flag_q[f] <= 1'b1;
        else if (flag_clr)    flag_q[f] <= 1'b0;
      end
    end
  endgenerate

  assign start_det = flag_q[0];
  assign done_irq  = flag_q[1];
  assign wcol      = flag_q[2];
  assign bcol      = flag_q[3];

  always_ff @(posedge clk) begin
    if (rst)                   txbuf_q <= '0;
    else if (txbuf_wr && !busy) txbuf_q <= txbuf_wdata;
  end
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen
  import i2c_rs_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_wr,
  input  logic                req_data,
  input  logic                other_busy,
  input  logic [RELOAD_W-1:0] reload_val,
  input  logic                sda_in,
  input  logic                scl_in,
  input  logic                txbuf_wr,
  input  logic [DATA_W-1:0]   txbuf_wdata,
  input  logic                flag_clr,
  output logic                sda_pull,
  output logic                scl_pull,
  output logic                rs_busy,
  output logic                start_det,
  output logic                done_irq,
  output logic                wcol,
  output logic                bcol,
  output logic [DATA_W-1:0]   txbuf_q
);
  logic      sda_s, scl_s, tout, cnt_load, done_evt, abort_evt;
  rs_state_t seq_state;

  i2c_rs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sda_raw(sda_in), .scl_raw(scl_in),
    .sda_s(sda_s), .scl_s(scl_s)
  );

  i2c_rs_baud #(.RELOAD_W(RELOAD_W)) u_baud (
    .clk(clk), .rst(rst), .load(cnt_load), .reload(reload_val), .tout(tout)
  );

  i2c_rs_seq u_seq (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_data(req_data),
    .other_busy(other_busy), .sda_s(sda_s), .scl_s(scl_s), .tout(tout),
    .state(seq_state), .cnt_load(cnt_load), .done_evt(done_evt),
    .abort_evt(abort_evt), .rs_busy(rs_busy), .sda_pull(sda_pull),
    .scl_pull(scl_pull)
  );

  i2c_rs_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .flag_clr(flag_clr), .done_evt(done_evt),
    .abort_evt(abort_evt), .busy(rs_busy), .sda_s(sda_s), .scl_s(scl_s),
    .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata), .start_det(start_det),
    .done_irq(done_irq), .wcol(wcol), .bcol(bcol), .txbuf_q(txbuf_q)
  );
endmodule

// File: rtl/i2c_rstart_gen_chk.sv
module i2c_rstart_gen_chk
  import i2c_rs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_wr,
  input logic              other_busy,
  input logic              sda_in,
  input logic              scl_in,
  input logic              txbuf_wr,
  input logic [DATA_W-1:0] txbuf_q,
  input logic              flag_clr,
  input logic              sda_pull,
  input logic              scl_pull,
  input logic              rs_busy,
  input logic              done_irq,
  input logic              wcol,
  input logic              bcol,
  input rs_state_t         seq_state
);
  p_reject_other_r2: assert property (@(posedge clk) disable iff (rst)
    (!rs_busy && other_busy && req_wr) |=> !rs_busy);

  p_accept_pulls_scl_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rs_busy) |-> (scl_pull && seq_state == RS_SCL_LOW));

  p_scl_held_sda_low_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_state == RS_SDA_REL && !sda_in) |=> scl_pull);

  p_done_holds_sda_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(seq_state) == RS_SDA_LOW && $fell(rs_busy)) |-> (done_irq && sda_pull && !scl_pull));

  p_wcol_keeps_buf_r8: assert property (@(posedge clk) disable iff (rst)
    (rs_busy && txbuf_wr) |=> (wcol && $stable(txbuf_q)));

  p_sda_low_at_rise_r10: assert property (@(posedge clk) disable iff (rst)
    (seq_state == RS_WAIT_SCL_HI && scl_in && !sda_in) |=> (bcol && !rs_busy && !scl_pull && !sda_pull));

  p_scl_drop_in_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (seq_state == RS_HIGH_HOLD && !scl_in) |=> (bcol && !rs_busy && !scl_pull && !sda_pull));

  p_bcol_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (bcol && !flag_clr) |=> bcol);
endmodule

bind i2c_rstart_gen i2c_rstart_gen_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .req_wr(req_wr), .other_busy(other_busy),
  .sda_in(sda_in), .scl_in(scl_in), .txbuf_wr(txbuf_wr), .txbuf_q(txbuf_q),
  .flag_clr(flag_clr), .sda_pull(sda_pull), .scl_pull(scl_pull),
  .rs_busy(rs_busy), .done_irq(done_irq), .wcol(wcol), .bcol(bcol),
  .seq_state(seq_state)
);

// File: tb/i2c_rstart_gen_tb_top.sv
module i2c_rstart_gen_tb_top;
  localparam int RW = 7;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_wr = 1'b0, req_data = 1'b0, other_busy = 1'b0;
  logic [RW-1:0] reload_val = '0;
  logic          txbuf_wr = 1'b0, flag_clr = 1'b0;
  logic [DW-1:0] txbuf_wdata = '0;
  logic          frc_sda = 1'b0, frc_scl = 1'b0;
  logic          sda_in, scl_in;
  logic          sda_pull, scl_pull, rs_busy, start_det, done_irq, wcol, bcol;
  logic [DW-1:0] txbuf_q;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  logic [DW-1:0] exp_buf;

  always #2 clk = ~clk;

  // open-drain bus: a line reads low if anyone pulls it
  assign sda_in = !(sda_pull || frc_sda);
  assign scl_in = !(scl_pull || frc_scl);

  i2c_rstart_gen #(.RELOAD_W(RW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_data(req_data),
    .other_busy(other_busy), .reload_val(reload_val), .sda_in(sda_in),
    .scl_in(scl_in), .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata),
    .flag_clr(flag_clr), .sda_pull(sda_pull), .scl_pull(scl_pull),
    .rs_busy(rs_busy), .start_det(start_det), .done_irq(done_irq),
    .wcol(wcol), .bcol(bcol), .txbuf_q(txbuf_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  // issue a request at the next edge (edge 0)
  task automatic request(input int n);
    reload_val = RW'(n);
    req_wr = 1'b1;
    req_data = 1'b1;
    tick();
    req_wr = 1'b0;
  endtask

  // full sequence with edge timing; mode 1 adds writes during the sequence
  task automatic run_seq(input int n, input bit mode);
    int k_scl = -1, k_sda = -1, k_sd = -1, k_done = -1, k_idle = -1;
    clear_flags();
    request(n);
    chk("R3 busy at accept", int'(rs_busy), 1);
    chk("R3 scl pulled at accept", int'(scl_pull), 1);
    for (int k = 1; k <= 3 * n + 8; k++) begin
      tick();
      if (k == 1) chk("R3 sda released after scl low", int'(sda_pull), 0);
      if (k_scl < 0 && !scl_pull) k_scl = k;
      if (k_sda < 0 && k >= 2 && sda_pull) k_sda = k;
      if (k_sd < 0 && start_det) k_sd = k;
      if (k_done < 0 && done_irq) k_done = k;
      if (k_idle < 0 && !rs_busy) k_idle = k;
      if (mode) begin
        txbuf_wr = 1'b0;
        req_wr   = 1'b0;
        if (k == 1) begin
          txbuf_wr = 1'b1; txbuf_wdata = ~exp_buf;
          req_wr = 1'b1;   req_data = 1'b0;
        end else if (k == 2) begin
          req_wr = 1'b1;   req_data = 1'b1;
        end
      end
    end
    chk("R4 scl release edge", k_scl, n + 2);
    chk("R5 sda pull edge", k_sda, 2 * n + 4);
    chk("R7 start detect edge", k_sd, 2 * n + 5);
    chk(mode ? "R9 completion edge with writes" : "R6 completion edge", k_done, 3 * n + 5);
    chk("R6 busy clear edge", k_idle, 3 * n + 5);
    chk("R6 sda held low at end", int'(sda_pull), 1);
    chk("R6 scl released at end", int'(scl_pull), 0);
    if (mode) begin
      chk("R8 wcol on busy write", int'(wcol), 1);
      chk("R8 buffer unchanged", int'(txbuf_q), int'(exp_buf));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit hold_ok;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 sda_pull", int'(sda_pull), 0);
    chk("R1 scl_pull", int'(scl_pull), 0);
    chk("R1 rs_busy", int'(rs_busy), 0);
    chk("R1 start_det", int'(start_det), 0);
    chk("R1 done_irq", int'(done_irq), 0);
    chk("R1 wcol", int'(wcol), 0);
    chk("R1 bcol", int'(bcol), 0);
    chk("R1 txbuf_q", int'(txbuf_q), 0);

    // R2 rejected requests
    other_busy = 1'b1;
    request(2);
    other_busy = 1'b0;
    chk("R2 busy with other event", int'(rs_busy), 0);
    chk("R2 scl with other event", int'(scl_pull), 0);
    req_wr = 1'b1; req_data = 1'b0;
    tick();
    req_wr = 1'b0;
    chk("R2 zero write no start", int'(rs_busy), 0);
    chk("R2 zero write no scl", int'(scl_pull), 0);

    // R8 idle write is stored
    exp_buf = 8'h3C;
    txbuf_wr = 1'b1; txbuf_wdata = exp_buf;
    tick();
    txbuf_wr = 1'b0;
    chk("R8 idle write stored", int'(txbuf_q), int'(exp_buf));
    chk("R8 idle write no wcol", int'(wcol), 0);

    // sweep of reload values
    for (int n = 0; n < 16; n++) run_seq(n, n[0]);
    run_seq(40, 1'b1);

    // R12 done flag sticky, then cleared
    repeat (3) tick();
    chk("R12 done_irq sticky", int'(done_irq), 1);
    clear_flags();
    chk("R12 done_irq cleared", int'(done_irq), 0);

    // R4 scl held while sda is held low by another device
    frc_sda = 1'b1;
    request(2);
    hold_ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (!scl_pull) hold_ok = 1'b0;
    end
    chk("R4 scl held while sda low", int'(hold_ok), 1);
    frc_sda = 1'b0;
    tick();
    chk("R4 scl released once sda high", int'(scl_pull), 0);
    for (int k = 0; k < 30 && rs_busy; k++) tick();
    chk("R6 completes after stretch", int'(done_irq), 1);
    clear_flags();

    // R10 sda low when scl rises
    request(3);
    for (int k = 0; k < 20 && scl_pull; k++) tick();
    frc_sda = 1'b1;
    tick();
    chk("R10 bcol set", int'(bcol), 1);
    chk("R10 busy cleared", int'(rs_busy), 0);
    chk("R10 scl released", int'(scl_pull), 0);
    chk("R10 sda released", int'(sda_pull), 0);
    frc_sda = 1'b0;
    repeat (4) tick();
    chk("R12 bcol sticky", int'(bcol), 1);
    clear_flags();
    chk("R12 bcol cleared", int'(bcol), 0);

    // R11 scl dropped during the both-high period
    request(4);
    for (int k = 0; k < 20 && scl_pull; k++) tick();
    tick();
    chk("R11 still busy in hold", int'(rs_busy), 1);
    chk("R11 no bcol yet", int'(bcol), 0);
    frc_scl = 1'b1;
    tick();
    chk("R11 bcol set", int'(bcol), 1);
    chk("R11 busy cleared", int'(rs_busy), 0);
    chk("R11 sda released", int'(sda_pull), 0);
    frc_scl = 1'b0;
    clear_flags();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule